// File: doc/BRIEF.md
# Product Register Multiply and Shift Unit

This unit holds a 32-bit signed product as a high word and a low word. On a start strobe it does one of eight operations and writes the result back into that pair. Four operations multiply: an accumulator word times an operand word, the same product taken as a Q15 fraction, or the stored pair times an operand word. The pair-times-operand multiply comes in a wrapping version and a clamping version. The other four operations shift the pair left or right by 0 to 31 bit positions, in plain or saturating form.

The surrounding core places the accumulator and the operand on the inputs. These come from a register or from an immediate field, which makes no difference to the unit. The core raises `start_i` for one cycle together with a 3-bit opcode. The result appears on the two output words one clock edge later, and `done_o` is high for that same cycle. All operands and results are signed two's complement.

Top module: `prod_shift_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the pair reads 0x00000000 and `done_o` is low until the first start.
- R2: Opcode 0 writes the signed 32-bit product of `acc_i` and `opnd_i` into the pair.
- R3: Opcode 1 writes twice the signed product of `acc_i` and `opnd_i` into the pair (Q15 fractional multiply). The single overflow case, 0x8000 times 0x8000, gives 0x7FFFFFFF.
- R4: Opcode 2 multiplies the signed pair by signed `opnd_i` and keeps the low 32 bits of the 48-bit product.
- R5: Opcode 3 is the same multiply as opcode 2, but a product outside the 32-bit signed range gives 0x7FFFFFFF when it is positive and 0x80000000 when it is negative.
- R6: Opcode 4 shifts the pair left by `shamt_i` and fills the low bits with zeros. Bit 31 keeps its old value, and bits 30..0 take bits 30..0 of the shifted value.
- R7: Opcode 5 shifts the pair right by `shamt_i` and fills the vacated upper bits with copies of bit 31.
- R8: Opcode 6 shifts the pair left by `shamt_i` and fills with zeros. If that shift would lose a significant bit or change the sign, the result is 0x7FFFFFFF for a non-negative pair and 0x80000000 for a negative pair.
- R9: Opcode 7 is the saturating right shift. An arithmetic right shift cannot overflow, so it gives the same result as opcode 5.
- R10: `done_o` is high in exactly the cycle after each cycle in which `start_i` is high. Without a start, the pair keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one operation this cycle |
| op_i | input | 3 | Opcode, 0..7 as listed in the requirements |
| acc_i | input | 16 | Accumulator word, signed |
| opnd_i | input | 16 | Register or immediate operand word, signed |
| shamt_i | input | 5 | Shift amount, 0..31 |
| prod_hi_o | output | 16 | Pair bits 31..16 |
| prod_lo_o | output | 16 | Pair bits 15..0 |
| done_o | output | 1 | Result valid, high one cycle after a start |

## Verification
The saturation paths are the hardest to reach from the ports. The pair can only be loaded through a multiply, so the bench has to build a large value first. It does this with a full-scale product such as 0x7FFF times 0x7FFF. It then multiplies that value back into the pair, or shifts it left past bit 30, to force both clamp polarities. The bench also chains a negative product into a 28-bit saturating left shift, and runs a long series of random operations. In that series each result feeds the next, so the pair wanders through large and small values of both signs.

// File: rtl/psu_pkg.sv
package psu_pkg;

  typedef enum logic [2:0] {
    OP_MUL   = 3'd0,
    OP_MULQ  = 3'd1,
    OP_PMUL  = 3'd2,
    OP_PMULS = 3'd3,
    OP_SHL   = 3'd4,
    OP_SHR   = 3'd5,
    OP_SHLS  = 3'd6,
    OP_SHRS  = 3'd7
  } psu_op_e;

endpackage

// File: rtl/psu_mult.sv
module psu_mult #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   opnd_i,
  input  logic [2*W-1:0] pair_i,
  output logic [2*W-1:0] prod_o,
  output logic [2*W-1:0] q15_o,
  output logic           q15_clamp_o,
  output logic [2*W-1:0] pmul_o,
  output logic [2*W-1:0] pmuls_o,
  output logic           pmul_clamp_o
);
  localparam int unsigned DW = 2 * W;
  localparam int unsigned XW = 3 * W;
  localparam logic [DW-1:0] MAX_D = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_D = {1'b1, {(DW-1){1'b0}}};
  localparam logic [W-1:0]  MIN_W = {1'b1, {(W-1){1'b0}}};

  // signed word x word, full DW-bit result
  function automatic logic [DW-1:0] f_word_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [DW-1:0] sa, sb;
    sa = {{W{a[W-1]}}, a};
    sb = {{W{b[W-1]}}, b};
    return sa * sb;
  endfunction

  // signed pair x word, full XW-bit result
  function automatic logic [XW-1:0] f_pair_mul(input logic [DW-1:0] p, input logic [W-1:0] b);
    logic signed [XW-1:0] sp, sb;
    sp = {{W{p[DW-1]}}, p};
    sb = {{DW{b[W-1]}}, b};
    return sp * sb;
  endfunction

  // true when the upper bits are not a pure sign extension of bit DW-1
  function automatic logic f_out_of_range(input logic [XW-1:0] v);
    return !((&v[XW-1:DW-1]) || !(|v[XW-1:DW-1]));
  endfunction

  logic [XW-1:0] pair_full;

  always_comb begin
    prod_o      = f_word_mul(acc_i, opnd_i);
    q15_clamp_o = (acc_i == MIN_W) && (opnd_i == MIN_W);
    q15_o       = q15_clamp_o ? MAX_D : {prod_o[DW-2:0], 1'b0};

    pair_full    = f_pair_mul(pair_i, opnd_i);
    pmul_o       = pair_full[DW-1:0];
    pmul_clamp_o = f_out_of_range(pair_full);
    pmuls_o      = pmul_clamp_o ? (pair_full[XW-1] ? MIN_D : MAX_D) : pmul_o;
  end

endmodule

// File: rtl/psu_shift.sv
module psu_shift #(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 5
) (
  input  logic [DW-1:0] pair_i,
  input  logic [NW-1:0] n_i,
  output logic [DW-1:0] shl_o,
  output logic [DW-1:0] shr_o,
  output logic [DW-1:0] shls_o,
  output logic          shls_clamp_o
);
  localparam logic [DW-1:0] MAX_D = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_D = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] rs [NW+1];
  logic [DW-1:0] ls [NW+1];
  logic [DW-1:0] undo;

  assign rs[0] = pair_i;
  assign ls[0] = pair_i;

  // log-depth barrel: stage s moves by 2**s when bit s of the amount is set
  for (genvar s = 0; s < NW; s++) begin : g_stage
    assign rs[s+1] = n_i[s] ? DW'($signed(rs[s]) >>> (2**s)) : rs[s];
    assign ls[s+1] = n_i[s] ? (ls[s] << (2**s)) : ls[s];
  end

  always_comb begin
    shr_o        = rs[NW];
    shl_o        = {pair_i[DW-1], ls[NW][DW-2:0]};
    undo         = DW'($signed(ls[NW]) >>> n_i);
    shls_clamp_o = (undo != pair_i);
    shls_o       = shls_clamp_o ? (pair_i[DW-1] ? MIN_D : MAX_D) : ls[NW];
  end

endmodule

// File: rtl/prod_shift_unit.sv
module prod_shift_unit #(
  parameter int unsigned W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [2:0]                  op_i,
  input  logic [W-1:0]                acc_i,
  input  logic [W-1:0]                opnd_i,
  input  logic [$clog2(2*W)-1:0]      shamt_i,
  output logic [W-1:0]                prod_hi_o,
  output logic [W-1:0]                prod_lo_o,
  output logic                        done_o
);
  import psu_pkg::*;

  localparam int unsigned DW = 2 * W;
  localparam int unsigned NW = $clog2(DW);

  psu_op_e       op;
  logic [DW-1:0] pair_q;
  logic [DW-1:0] pair_next;
  logic          done_q;

  // named internal events, observed by the checker
  logic          sat_event;

  logic [DW-1:0] prod_w, q15_w, pmul_w, pmuls_w;
  logic          q15_clamp_w, pmul_clamp_w;
  logic [DW-1:0] shl_w, shr_w, shls_w;
  logic          shls_clamp_w;

  assign op = psu_op_e'(op_i);

  psu_mult #(.W(W)) u_mult (
    .acc_i        (acc_i),
    .opnd_i       (opnd_i),
    .pair_i       (pair_q),
    .prod_o       (prod_w),
    .q15_o        (q15_w),
    .q15_clamp_o  (q15_clamp_w),
    .pmul_o       (pmul_w),
    .pmuls_o      (pmuls_w),
    .pmul_clamp_o (pmul_clamp_w)
  );

  psu_shift #(.DW(DW), .NW(NW)) u_shift (
    .pair_i       (pair_q),
    .n_i          (shamt_i),
    .shl_o        (shl_w),
    .shr_o        (shr_w),
    .shls_o       (shls_w),
    .shls_clamp_o (shls_clamp_w)
  );

  always_comb begin
    pair_next = pair_q;
    sat_event = 1'b0;
    unique case (op)
      OP_MUL:   pair_next = prod_w;
      OP_MULQ:  begin pair_next = q15_w;   sat_event = q15_clamp_w;  end
      OP_PMUL:  pair_next = pmul_w;
      OP_PMULS: begin pair_next = pmuls_w; sat_event = pmul_clamp_w; end
      OP_SHL:   pair_next = shl_w;
      OP_SHR:   pair_next = shr_w;
      OP_SHLS:  begin pair_next = shls_w;  sat_event = shls_clamp_w; end
      OP_SHRS:  pair_next = shr_w;
      default:  pair_next = pair_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= start_i;
      if (start_i) pair_q <= pair_next;
    end
  end

  assign prod_hi_o = pair_q[DW-1:W];
  assign prod_lo_o = pair_q[W-1:0];
  assign done_o    = done_q;

endmodule

// File: rtl/psu_checker.sv
module psu_checker #(
  parameter int unsigned W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic [2:0]             op_i,
  input logic [W-1:0]           prod_hi_o,
  input logic [W-1:0]           prod_lo_o,
  input logic                   done_o,
  input logic                   sat_event
);
  localparam int unsigned DW = 2 * W;
  localparam logic [DW-1:0] MAX_D = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_D = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] pair;
  assign pair = {prod_hi_o, prod_lo_o};

  a_r10_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  a_r10_no_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);

  a_r10_pair_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(pair));

  a_r6_shl_keeps_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i == 3'd4) |=> pair[DW-1] == $past(pair[DW-1]));

  a_r7_shr_keeps_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (op_i == 3'd5 || op_i == 3'd7)) |=> pair[DW-1] == $past(pair[DW-1]));

  a_r8_shls_keeps_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i == 3'd6) |=> pair[DW-1] == $past(pair[DW-1]));

  a_r3_q15_never_min: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i == 3'd1) |=> pair != MIN_D);

  a_r5_clamp_gives_extreme: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && sat_event) |=> (pair == MAX_D || pair == MIN_D));

endmodule

bind prod_shift_unit psu_checker #(.W(W)) u_psu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .op_i      (op_i),
  .prod_hi_o (prod_hi_o),
  .prod_lo_o (prod_lo_o),
  .done_o    (done_o),
  .sat_event (sat_event)
);

// File: tb/prod_shift_unit_bench.sv
module prod_shift_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] acc_i = '0;
  logic [15:0] opnd_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [15:0] prod_hi_o, prod_lo_o;
  logic        done_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] model_pair = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  prod_shift_unit u_prod_shift_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .shamt_i(shamt_i),
    .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam longint MAXL = 64'sd2147483647;
  localparam longint MINL = -64'sd2147483648;

  function automatic longint clamp32(input longint v);
    if (v > MAXL) return MAXL;
    if (v < MINL) return MINL;
    return v;
  endfunction

  // reference model built on 64-bit integer arithmetic
  function automatic logic [31:0] model(input logic [2:0] op, input logic [15:0] a,
                                        input logic [15:0] b, input logic [4:0] n,
                                        input logic [31:0] p);
    longint sa, sb, sp, v;
    logic [63:0] u;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    sp = longint'($signed(p));
    case (op)
      3'd0: v = sa * sb;
      3'd1: v = clamp32(2 * sa * sb);
      3'd2: v = sp * sb;
      3'd3: v = clamp32(sp * sb);
      3'd4: begin
        v = sp * (64'sd1 <<< n);
        u = v;
        return {p[31], u[30:0]};
      end
      3'd6: v = clamp32(sp * (64'sd1 <<< n));
      default: v = sp >>> n;
    endcase
    u = v;
    return u[31:0];
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // driver: one-cycle start, expected result goes to the scoreboard
  task automatic do_op(input logic [2:0] op, input logic [15:0] a,
                       input logic [15:0] b, input logic [4:0] n);
    @(negedge clk);
    op_i = op; acc_i = a; opnd_i = b; shamt_i = n; start_i = 1'b1;
    model_pair = model(op, a, b, n, model_pair);
    exp_q.push_back(model_pair);
    tag_q.push_back(req_of(op));
  endtask

  task automatic go_idle(input int cycles);
    @(negedge clk);
    start_i = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  // monitor: pops the scoreboard whenever a result is flagged
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R10 done without start: got=1 exp=0");
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({prod_hi_o, prod_lo_o} !== e) begin
          bad++;
          $display("FAIL %s pair got=%h exp=%h", t, {prod_hi_o, prod_lo_o}, e);
        end
      end
    end
  end

  task automatic check_idle(input string t);
    total++;
    if (done_o !== 1'b0 || {prod_hi_o, prod_lo_o} !== model_pair) begin
      bad++;
      $display("FAIL %s idle got=%h done=%b exp=%h done=0", t,
               {prod_hi_o, prod_lo_o}, done_o, model_pair);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check_idle("R1");                 // R1 during reset
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1");                 // R1 after release

    // R2 plain products
    do_op(3'd0, 16'd3, 16'hFFFB, 5'd0);
    do_op(3'd0, 16'h7FFF, 16'h7FFF, 5'd0);
    do_op(3'd0, 16'h8000, 16'h8000, 5'd0);
    // R3 fractional, including the clamp case
    do_op(3'd1, 16'h8000, 16'h8000, 5'd0);
    do_op(3'd1, 16'h4000, 16'h4000, 5'd0);
    do_op(3'd1, 16'h8000, 16'h7FFF, 5'd0);
    // R4 / R5 pair times operand
    do_op(3'd0, 16'h7FFF, 16'h7FFF, 5'd0);
    do_op(3'd2, 16'h0, 16'd4, 5'd0);
    do_op(3'd0, 16'h7FFF, 16'h7FFF, 5'd0);
    do_op(3'd3, 16'h0, 16'd4, 5'd0);      // positive clamp
    do_op(3'd3, 16'h0, 16'hFFFE, 5'd0);   // negative clamp
    do_op(3'd0, 16'd100, 16'd200, 5'd0);
    do_op(3'd3, 16'h0, 16'hFFFD, 5'd0);   // in range
    do_op(3'd2, 16'h0, 16'hFFFF, 5'd0);
    // R6 plain left shift keeps bit 31
    do_op(3'd0, 16'h8000, 16'h8000, 5'd0);
    do_op(3'd4, 16'h0, 16'h0, 5'd1);
    do_op(3'd0, 16'd3, 16'hFFFB, 5'd0);
    do_op(3'd4, 16'h0, 16'h0, 5'd4);
    do_op(3'd4, 16'h0, 16'h0, 5'd31);
    // R7 arithmetic right shift
    do_op(3'd1, 16'h8000, 16'h7FFF, 5'd0);
    do_op(3'd5, 16'h0, 16'h0, 5'd4);
    do_op(3'd5, 16'h0, 16'h0, 5'd31);
    // R8 saturating left shift
    do_op(3'd0, 16'h7FFF, 16'h7FFF, 5'd0);
    do_op(3'd6, 16'h0, 16'h0, 5'd1);
    do_op(3'd6, 16'h0, 16'h0, 5'd0);
    do_op(3'd6, 16'h0, 16'h0, 5'd2);
    do_op(3'd0, 16'd3, 16'hFFFB, 5'd0);
    do_op(3'd6, 16'h0, 16'h0, 5'd27);
    do_op(3'd0, 16'd3, 16'hFFFB, 5'd0);
    do_op(3'd6, 16'h0, 16'h0, 5'd28);
    // R9 saturating right shift
    do_op(3'd0, 16'h8000, 16'h7FFF, 5'd0);
    do_op(3'd7, 16'h0, 16'h0, 5'd31);
    do_op(3'd0, 16'h7FFF, 16'h7FFF, 5'd0);
    do_op(3'd7, 16'h0, 16'h0, 5'd9);

    // R10 hold with no start
    go_idle(4);
    check_idle("R10");

    // mixed random sequence, chained through the pair
    for (int i = 0; i < 200; i++) begin
      do_op(3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom), 5'($urandom));
      if (i % 17 == 0) begin
        go_idle(2);
        check_idle("R10");
      end
    end
    go_idle(3);
    check_idle("R10");

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R10 results missing: got=%0d pending exp=0", exp_q.size());
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule